// File: doc/BRIEF.md
# External Bus Strobe Sequencer

This block sets the rhythm of an 8-bit controller's multiplexed external memory bus. It divides the oscillator clock into machine cycles of six states, two clocks per state. From each cycle's bus activity it produces three things. The address-latch strobe goes high twice per cycle. The active-low code-read strobe goes low twice per cycle while code is read from outside. Decoded state and phase strobes let the neighbouring address/data multiplexer know which slot of the cycle it is in.

The core reports the activity of the coming cycle before that cycle begins. The activity codes are: 0 internal fetch, 1 external code fetch, 2 external data transfer, 3 code-table read. Along with the code the core gives three settings: a latch-strobe mask bit, an external-execution flag, and a wide-address flag. All four are captured only at the last clock of a cycle and hold for the whole of the next one.

An external data transfer omits the first latch pulse and both code-read pulses of its cycle. The mask bit limits latch pulses to data and table cycles, but it has no effect while the core executes from external memory. A high-port select shows when that port must carry the upper address byte, rather than its own register contents.

Top module: `bus_strobe_seq`

## Requirements
- R1: While reset is high and on the first clock after it, the sequencer is at tick 0 (state S1, early phase), ale is low, psen_n is high, and the captured setting is activity 0 with the mask clear and external execution clear.
- R2: A machine cycle is 12 clocks, numbered tick 0 to 11. state_oh is one-hot with bit i set during ticks 2i and 2i+1. late_phase is high on odd ticks.
- R3: In a cycle whose latch strobe is enabled, ale is high on ticks 1-2 and on ticks 7-8, two clocks per pulse, and low on every other tick.
- R4: In an external data cycle (activity code 2), the ale pulse on ticks 1-2 is omitted and the pulse on ticks 7-8 remains.
- R5: For activity codes 1 and 3, psen_n is low on ticks 4-5 and 10-11 and high otherwise. ale has always fallen at least one clock before psen_n falls.
- R6: For activity codes 0 and 2, psen_n stays high for the whole cycle.
- R7: With ale_mask high and ext_run low, ale stays low throughout cycles with activity 0 or 1. Cycles with activity 2 or 3 still pulse, following R3 and R4.
- R8: With ext_run high, ale_mask has no effect on ale.
- R9: hi_addr_drive is high for the whole cycle for activity codes 1 and 3. For code 2 it equals the captured wide_addr. For code 0 it is low.
- R10: The inputs are captured only on the clock edge that ends tick 11. Any value they take during a cycle shapes the next cycle and never the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_kind | input | 2 | Activity of the next machine cycle (0 internal, 1 external code, 2 external data, 3 table read) |
| ale_mask | input | 1 | Latch-strobe mask setting for the next cycle |
| ext_run | input | 1 | Core executes from external program memory |
| wide_addr | input | 1 | Next data transfer uses a 16-bit address |
| ale | output | 1 | Address-latch strobe, active high |
| psen_n | output | 1 | Code-read strobe, active low |
| state_oh | output | 6 | One-hot machine-cycle state S1..S6 |
| late_phase | output | 1 | High in the second clock of each state |
| hi_addr_drive | output | 1 | High port must carry the upper address byte |

## Verification
The checker watches properties of every cycle. It confirms that each ale pulse is exactly two clocks wide and that state_oh stays one-hot and moves only after a late phase. It also confirms that psen_n never overlaps ale and falls only after ale has dropped, that data cycles never drive psen_n and lose their first pulse, and that a mask without external execution silences ale in fetch cycles. The exact tick of every edge, the capture of the inputs at the cycle boundary, the high-port select, and recovery from a reset in mid-cycle need the bench's sweep over all settings. In that sweep the expected waveform is computed tick by tick.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

    localparam int N_STATES = 6;

    typedef enum logic [1:0] {
        BK_INTERNAL = 2'd0,
        BK_CODE_EXT = 2'd1,
        BK_DATA_EXT = 2'd2,
        BK_TABLE    = 2'd3
    } bus_kind_e;

    typedef struct packed {
        bus_kind_e kind;
        logic      ale_mask;
        logic      ext_run;
        logic      wide;
    } cycle_cfg_t;

    localparam cycle_cfg_t CFG_RESET = '{kind: BK_INTERNAL, ale_mask: 1'b0,
                                         ext_run: 1'b0, wide: 1'b0};

    function automatic logic is_code_read(bus_kind_e k);
        return (k == BK_CODE_EXT) || (k == BK_TABLE);
    endfunction

    function automatic logic ale_gate(cycle_cfg_t c);
        return !c.ale_mask || c.ext_run || (c.kind == BK_DATA_EXT) || (c.kind == BK_TABLE);
    endfunction

    function automatic logic in_win(int t, int lo, int hi);
        return (t >= lo) && (t <= hi);
    endfunction

endpackage

// File: rtl/bseq_timer.sv
module bseq_timer
    import bus_seq_pkg::*;
#(
    parameter int TPS = 2
) (
    input  logic                                 clk,
    input  logic                                 rst,
    output logic [$clog2(N_STATES*TPS)-1:0]      tick,
    output logic [N_STATES-1:0]                  state_oh,
    output logic                                 late_phase,
    output logic                                 last_tick
);
    localparam int TW = $clog2(N_STATES*TPS);
    localparam int SW = $clog2(N_STATES);
    localparam int PW = (TPS > 1) ? $clog2(TPS) : 1;

    logic [PW-1:0] ph_q;
    logic [SW-1:0] st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q <= '0;
            st_q <= '0;
        end else if (ph_q == PW'(TPS - 1)) begin
            ph_q <= '0;
            st_q <= (st_q == SW'(N_STATES - 1)) ? '0 : st_q + 1'b1;
        end else begin
            ph_q <= ph_q + 1'b1;
        end
    end

    generate
        for (genvar i = 0; i < N_STATES; i++) begin : g_state
            assign state_oh[i] = (st_q == SW'(i));
        end
    endgenerate

    assign late_phase = (ph_q == PW'(TPS - 1));
    assign last_tick  = (st_q == SW'(N_STATES - 1)) && late_phase;
    assign tick       = TW'(st_q) * TW'(TPS) + TW'(ph_q);

endmodule

// File: rtl/bseq_cfg.sv
module bseq_cfg
    import bus_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [1:0] kind_in,
    input  logic       mask_in,
    input  logic       ext_in,
    input  logic       wide_in,
    output cycle_cfg_t cfg_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else if (load) begin
            cfg_q.kind     <= bus_kind_e'(kind_in);
            cfg_q.ale_mask <= mask_in;
            cfg_q.ext_run  <= ext_in;
            cfg_q.wide     <= wide_in;
        end
    end
endmodule

// File: rtl/bseq_strobes.sv
module bseq_strobes
    import bus_seq_pkg::*;
#(
    parameter int TPS = 2
) (
    input  logic [$clog2(N_STATES*TPS)-1:0] tick,
    input  cycle_cfg_t                      cfg,
    output logic                            ale,
    output logic                            psen_n,
    output logic                            hi_addr_drive
);
    localparam int ALE_A_LO = TPS - 1;
    localparam int ALE_A_HI = 2 * TPS - 2;
    localparam int ALE_B_LO = 4 * TPS - 1;
    localparam int ALE_B_HI = 5 * TPS - 2;
    localparam int RD_A_LO  = 2 * TPS;
    localparam int RD_A_HI  = 3 * TPS - 1;
    localparam int RD_B_LO  = 5 * TPS;
    localparam int RD_B_HI  = 6 * TPS - 1;

    logic win_a, win_b, rd_win, code_rd;

    always_comb begin
        win_a   = in_win(int'(tick), ALE_A_LO, ALE_A_HI);
        win_b   = in_win(int'(tick), ALE_B_LO, ALE_B_HI);
        rd_win  = in_win(int'(tick), RD_A_LO, RD_A_HI) || in_win(int'(tick), RD_B_LO, RD_B_HI);
        code_rd = is_code_read(cfg.kind);

        ale           = ale_gate(cfg) && ((win_a && (cfg.kind != BK_DATA_EXT)) || win_b);
        psen_n        = !(code_rd && rd_win);
        hi_addr_drive = code_rd || ((cfg.kind == BK_DATA_EXT) && cfg.wide);
    end
endmodule

// File: rtl/bus_strobe_seq.sv
module bus_strobe_seq
    import bus_seq_pkg::*;
#(
    parameter int TPS = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          bus_kind,
    input  logic                ale_mask,
    input  logic                ext_run,
    input  logic                wide_addr,
    output logic                ale,
    output logic                psen_n,
    output logic [N_STATES-1:0] state_oh,
    output logic                late_phase,
    output logic                hi_addr_drive
);
    localparam int TW = $clog2(N_STATES*TPS);

    logic [TW-1:0] tick;
    logic          last_tick;
    cycle_cfg_t    cfg_q;

    bseq_timer #(.TPS(TPS)) i_timer (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .state_oh   (state_oh),
        .late_phase (late_phase),
        .last_tick  (last_tick)
    );

    bseq_cfg i_cfg (
        .clk     (clk),
        .rst     (rst),
        .load    (last_tick),
        .kind_in (bus_kind),
        .mask_in (ale_mask),
        .ext_in  (ext_run),
        .wide_in (wide_addr),
        .cfg_q   (cfg_q)
    );

    bseq_strobes #(.TPS(TPS)) i_strobes (
        .tick          (tick),
        .cfg           (cfg_q),
        .ale           (ale),
        .psen_n        (psen_n),
        .hi_addr_drive (hi_addr_drive)
    );
endmodule

// File: rtl/bus_strobe_seq_chk.sv
module bus_strobe_seq_chk
    import bus_seq_pkg::*;
#(
    parameter int TPS = 2
) (
    input logic                clk,
    input logic                rst,
    input logic                ale,
    input logic                psen_n,
    input logic [N_STATES-1:0] state_oh,
    input logic                late_phase,
    input logic [1:0]          cur_kind,
    input logic                cur_mask,
    input logic                cur_ext
);
    localparam int CW = $clog2(TPS + 2);

    logic [CW-1:0] hi_run;

    always_ff @(posedge clk) begin
        if (rst)                       hi_run <= '0;
        else if (!ale)                 hi_run <= '0;
        else if (hi_run != {CW{1'b1}}) hi_run <= hi_run + 1'b1;
    end

    AST_ALE_TWO_CLK: assert property (@(posedge clk) disable iff (rst)
        $fell(ale) |-> (hi_run == CW'(TPS)));                            // R3

    AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $countones(state_oh) == 1);                                      // R2

    AST_STATE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(late_phase) |-> $stable(state_oh));                       // R2

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(ale && !psen_n));                                              // R5

    AST_PSEN_AFTER_ALE: assert property (@(posedge clk) disable iff (rst)
        $fell(psen_n) |-> (!ale && !$past(ale)));                        // R5

    AST_DATA_NO_PSEN: assert property (@(posedge clk) disable iff (rst)
        (cur_kind == 2'd2) |-> psen_n);                                  // R6

    AST_DATA_SKIP: assert property (@(posedge clk) disable iff (rst)
        ((cur_kind == 2'd2) && (state_oh[0] || (state_oh[1] && !late_phase))) |-> !ale); // R4

    AST_MASK_QUIET: assert property (@(posedge clk) disable iff (rst)
        (cur_mask && !cur_ext && !cur_kind[1]) |-> !ale);                // R7
endmodule

bind bus_strobe_seq bus_strobe_seq_chk #(.TPS(TPS)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .ale        (ale),
    .psen_n     (psen_n),
    .state_oh   (state_oh),
    .late_phase (late_phase),
    .cur_kind   (cfg_q.kind),
    .cur_mask   (cfg_q.ale_mask),
    .cur_ext    (cfg_q.ext_run)
);

// File: tb/test_bus_strobe_seq.sv
`timescale 1ns/1ps
module test_bus_strobe_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_kind = 2'd0;
    logic       ale_mask = 1'b0, ext_run = 1'b0, wide_addr = 1'b0;
    logic       ale, psen_n, late_phase, hi_addr_drive;
    logic [5:0] state_oh;

    int n_tot = 0, n_bad = 0;
    bit done = 1'b0;
    int pk = 0, pm = 0, pe = 0, pw = 0;

    always #2.5 clk = ~clk;

    bus_strobe_seq i_bus_strobe_seq (
        .clk(clk), .rst(rst), .bus_kind(bus_kind), .ale_mask(ale_mask),
        .ext_run(ext_run), .wide_addr(wide_addr), .ale(ale), .psen_n(psen_n),
        .state_oh(state_oh), .late_phase(late_phase), .hi_addr_drive(hi_addr_drive)
    );

    task automatic chk(string req, int act, int exp);
        n_tot++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d time=%0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_ale(int t, int k, int m, int e);
        int en = (!m || e || k == 2 || k == 3) ? 1 : 0;
        int pa = (t == 1 || t == 2) && (k != 2);
        int pb = (t == 7 || t == 8);
        return (en != 0 && (pa || pb)) ? 1 : 0;
    endfunction

    function automatic int exp_psen_n(int t, int k);
        int rd = (k == 1 || k == 3) && (t == 4 || t == 5 || t == 10 || t == 11);
        return rd ? 0 : 1;
    endfunction

    function automatic int exp_hi(int k, int w);
        return (k == 1 || k == 3 || (k == 2 && w != 0)) ? 1 : 0;
    endfunction

    // At a negedge with tick 0: drive next-cycle inputs, check the current cycle (R10).
    task automatic run_cycle(int k, int m, int e, int w);
        bus_kind = 2'(k); ale_mask = 1'(m); ext_run = 1'(e); wide_addr = 1'(w);
        for (int t = 0; t < 12; t++) begin
            chk("R2 state_oh", int'(state_oh), 1 << (t / 2));
            chk("R2 late_phase", int'(late_phase), t % 2);
            chk((pk == 2) ? "R4 ale" : (pm != 0 && pe == 0) ? "R7 ale" :
                (pe != 0) ? "R8 ale" : "R3 ale",
                int'(ale), exp_ale(t, pk, pm, pe));
            chk((pk == 1 || pk == 3) ? "R5 psen_n" : "R6 psen_n",
                int'(psen_n), exp_psen_n(t, pk));
            chk("R9 hi_addr_drive", int'(hi_addr_drive), exp_hi(pk, pw));
            if (t == 6) begin
                // mid-cycle disturbance must not affect this cycle (R10)
                bus_kind = ~bus_kind; ale_mask = ~ale_mask; ext_run = ~ext_run; wide_addr = ~wide_addr;
            end
            if (t == 7) begin
                bus_kind = 2'(k); ale_mask = 1'(m); ext_run = 1'(e); wide_addr = 1'(w);
            end
            @(negedge clk);
        end
        pk = k; pm = m; pe = e; pw = w;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 ale in reset", int'(ale), 0);
        chk("R1 psen_n in reset", int'(psen_n), 1);
        chk("R1 state in reset", int'(state_oh), 1);
        rst = 1'b0;
        chk("R1 ale after reset", int'(ale), 0);
        chk("R1 psen_n after reset", int'(psen_n), 1);
        chk("R1 state after reset", int'(state_oh), 1);
        chk("R1 late_phase after reset", int'(late_phase), 0);
        pk = 0; pm = 0; pe = 0; pw = 0;
        for (int k = 0; k < 4; k++)
            for (int m = 0; m < 2; m++)
                for (int e = 0; e < 2; e++)
                    for (int w = 0; w < 2; w++)
                        run_cycle(k, m, e, w);
        run_cycle(2, 1, 0, 1);
        run_cycle(1, 1, 0, 0);
        run_cycle(0, 0, 0, 0);
        // reset in mid-cycle
        repeat (5) @(negedge clk);
        rst = 1'b1;
        bus_kind = 2'd2; ale_mask = 1'b1; ext_run = 1'b0; wide_addr = 1'b1;
        repeat (14) @(negedge clk);
        chk("R1 state after mid-cycle reset", int'(state_oh), 1);
        chk("R1 psen_n after mid-cycle reset", int'(psen_n), 1);
        rst = 1'b0;
        pk = 0; pm = 0; pe = 0; pw = 0;
        run_cycle(0, 0, 0, 0);
        run_cycle(0, 0, 0, 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tot++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_tot, n_bad);
            $finish;
        end
    end
endmodule